// File: doc/BRIEF.md
# External Data Wait-State Generator

This block sits between a processor core's data-memory port and the external data bus. It holds back, through a stall output, accesses that fall in the upper external data window (addresses C000h and above). It keeps a 16-bit wait-cycle register that the core reads and writes as a memory-mapped location. Each of the two data memory spaces, X and Y, has its own 2-bit count code in that register. The codes select 0, 1, 3 or 7 wait cycles. A slow device can lengthen an access further through an asynchronous wait pin, which the block synchronises first.

The core raises `acc_req_i` with the address and the space select. While `stall_o` is high it holds all three unchanged. The access completes in the first cycle in which the request is high and the stall is low. The block is built around a three-state controller:

- **IDLE**: waits for a request.
  - *start-count*: a request in the window with a nonzero count moves to COUNT, or to TAIL when the count is one.
  - *start-pin*: a request in the window with a zero count and the synchronised pin active moves to TAIL.
  - *pass*: any other request completes in place.
- **COUNT**: stalls and decrements the latched count.
  - *expire*: leaves for TAIL when the count reaches one.
- **TAIL**: stalls only while the synchronised pin is active.
  - *release*: returns to IDLE once the pin is inactive.

Top module: `extwait_gen`

## Requirements
- R1: After reset, `cfg_rdata_o` reads 000Fh, which is 7 waits for both spaces.
- R2: A cycle with `cfg_we_i` high stores `cfg_wdata_i[3:0]`. Read-back of bits 15:4 is always zero.
- R3: Space X (`acc_space_i`=0) takes its code from bits 1:0. Space Y (`acc_space_i`=1) takes its code from bits 3:2. The codes decode as 00 to 0 waits, 01 to 1, 10 to 3 and 11 to 7.
- R4: With the synchronised pin inactive, a request at an address of C000h or above has `stall_o` high from its first cycle for exactly N cycles, where N is the decoded count. The access completes in cycle N, counting the first cycle as 0.
- R5: A request below C000h never raises `stall_o`, whatever the register value or the pin.
- R6: The wait pin passes through two flip-flops. Once the count has expired, the stall stays high while the synchronised pin is active. Suppose the pin has been high for at least two cycles before the access and is lowered in access cycle j. The stall then lasts max(N, j+2) cycles.
- R7: The count is latched when an access starts. A register write during the access does not change that access's length.
- R8: A new request in the cycle right after a completion starts a fresh, full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Write strobe for the wait-cycle register |
| cfg_wdata_i | input | 16 | Register write data |
| cfg_rdata_o | output | 16 | Register read-back |
| acc_req_i | input | 1 | Core data access request |
| acc_space_i | input | 1 | Space select: 0 is X, 1 is Y |
| acc_addr_i | input | 16 | Access address |
| ext_wait_i | input | 1 | Asynchronous wait request from the external device |
| stall_o | output | 1 | Holds the core's access while high |

## Verification
The assertions assume that the core keeps the request, the address and the space select unchanged while it is stalled, and that the request is low during reset. The bench drives each access as one held request and changes it only after the completion cycle, so it stays within that assumption. The pin is raised at least two cycles before an access that should see it, and the expected stall length is computed from the synchroniser delay. The bench sweeps every register value, both spaces, addresses at and around the window edge, and pin release cycles.

// File: rtl/extwait_pkg.sv
package extwait_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_TAIL  = 2'd2
    } wait_state_e;

    // Code c selects 2**c - 1 wait cycles: 0, 1, 3, 7 for a 2-bit code.
    function automatic int unsigned code_to_waits(input int unsigned code);
        return (32'd1 << code) - 32'd1;
    endfunction

endpackage

// File: rtl/extwait_cfg_reg.sv
module extwait_cfg_reg #(
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 2,
    parameter int N_SPACE = 2,
    localparam int SP_W   = (N_SPACE > 1) ? $clog2(N_SPACE) : 1,
    localparam int USED_W = FIELD_W * N_SPACE
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               we_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [SP_W-1:0]    space_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [FIELD_W-1:0] code_o
);

    logic [N_SPACE-1:0][FIELD_W-1:0] fld_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fld_q <= '1;
        end else if (we_i) begin
            fld_q <= wdata_i[USED_W-1:0];
        end
    end

    // Read-back: one field per space, packed from bit 0 upward.
    generate
        for (genvar s = 0; s < N_SPACE; s++) begin : g_rd
            assign rdata_o[s*FIELD_W +: FIELD_W] = fld_q[s];
        end
        if (DATA_W > USED_W) begin : g_pad
            assign rdata_o[DATA_W-1:USED_W] = '0;
        end
    endgenerate

    always_comb begin
        code_o = '0;
        for (int s = 0; s < N_SPACE; s++) begin
            if (space_i == SP_W'(s)) begin
                code_o = fld_q[s];
            end
        end
    end

    // R2
    wr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> (rdata_o == {{(DATA_W-USED_W){1'b0}}, $past(wdata_i[USED_W-1:0])}));

endmodule

// File: rtl/extwait_sync.sv
module extwait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/extwait_fsm.sv
module extwait_fsm
    import extwait_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             go_i,
    input  logic [CNT_W-1:0] waits_i,
    input  logic             wait_s_i,
    output logic             stall_o,
    output wait_state_e      state_o
);

    wait_state_e      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (go_i) begin
                    if (waits_i == '0) begin
                        if (wait_s_i) st_d = ST_TAIL;
                    end else begin
                        cnt_d = waits_i - 1'b1;
                        st_d  = (waits_i == CNT_W'(1)) ? ST_TAIL : ST_COUNT;
                    end
                end
            end
            ST_COUNT: begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) st_d = ST_TAIL;
            end
            ST_TAIL: begin
                if (!wait_s_i) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE:  stall_o = go_i && ((waits_i != '0) || wait_s_i);
            ST_COUNT: stall_o = 1'b1;
            ST_TAIL:  stall_o = wait_s_i;
            default:  stall_o = 1'b0;
        endcase
    end

    assign state_o = st_q;

    // R4
    cnt_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_COUNT) |-> (cnt_q != '0));

    // R7
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_COUNT) |=> ((st_q == ST_TAIL) || (cnt_q == $past(cnt_q) - 1'b1)));

    // R6
    tail_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_TAIL && !wait_s_i) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/extwait_gen.sv
module extwait_gen
    import extwait_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 16,
    parameter int          FIELD_W     = 2,
    parameter int          N_SPACE     = 2,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] WIN_BASE    = 16'hC000,
    localparam int SP_W     = (N_SPACE > 1) ? $clog2(N_SPACE) : 1,
    localparam int MAX_WAIT = (1 << ((1 << FIELD_W) - 1)) - 1,
    localparam int CNT_W    = $clog2(MAX_WAIT + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [DATA_W-1:0] cfg_rdata_o,
    input  logic              acc_req_i,
    input  logic [SP_W-1:0]   acc_space_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              ext_wait_i,
    output logic              stall_o
);

    logic [FIELD_W-1:0] code;
    logic [CNT_W-1:0]   waits;
    logic               wait_s;
    logic               in_win;
    wait_state_e        fsm_st;

    extwait_cfg_reg #(
        .DATA_W (DATA_W),
        .FIELD_W(FIELD_W),
        .N_SPACE(N_SPACE)
    ) cfg_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (cfg_we_i),
        .wdata_i(cfg_wdata_i),
        .space_i(acc_space_i),
        .rdata_o(cfg_rdata_o),
        .code_o (code)
    );

    extwait_sync #(
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(ext_wait_i),
        .sync_o (wait_s)
    );

    assign in_win = (acc_addr_i >= ADDR_W'(WIN_BASE));
    assign waits  = CNT_W'(code_to_waits(int'(code)));

    extwait_fsm #(
        .CNT_W(CNT_W)
    ) fsm_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .go_i    (acc_req_i && in_win),
        .waits_i (waits),
        .wait_s_i(wait_s),
        .stall_o (stall_o),
        .state_o (fsm_st)
    );

    // R5
    outside_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_st == ST_IDLE && acc_req_i && (acc_addr_i < ADDR_W'(WIN_BASE))) |-> !stall_o);

    // R4
    req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_o && acc_req_i) |=> (acc_req_i && $stable(acc_addr_i) && $stable(acc_space_i)));

endmodule

// File: tb/extwait_gen_tb.sv
`timescale 1ns/100ps
module extwait_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        acc_req = 1'b0;
    logic        acc_space = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        ext_wait = 1'b0;
    logic        stall;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    extwait_gen dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cfg_we_i   (cfg_we),
        .cfg_wdata_i(cfg_wdata),
        .cfg_rdata_o(cfg_rdata),
        .acc_req_i  (acc_req),
        .acc_space_i(acc_space),
        .acc_addr_i (acc_addr),
        .ext_wait_i (ext_wait),
        .stall_o    (stall)
    );

    function automatic int dec(input int code);
        return (1 << code) - 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the completion cycle.
    task automatic access(input bit sp, input logic [15:0] addr, input int drop_at,
                          input int wr_at, input logic [15:0] wr_val,
                          input int exp, input string req);
        int c = 0;
        acc_req   = 1'b1;
        acc_space = sp;
        acc_addr  = addr;
        forever begin
            if (c == drop_at) ext_wait = 1'b0;
            if (c == wr_at) begin
                cfg_we    = 1'b1;
                cfg_wdata = wr_val;
            end else begin
                cfg_we = 1'b0;
            end
            #1;
            if (!stall) break;
            @(negedge clk);
            c++;
            if (c > 60) break;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check(c == exp, req, c, exp);
    endtask

    task automatic write_reg(input logic [15:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        acc_req = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [15:0] addrs [5];
        addrs = '{16'hC000, 16'hFFFF, 16'hD5A3, 16'h0000, 16'hBFFF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset value and quiet stall
        check(cfg_rdata == 16'h000F, "R1", int'(cfg_rdata), 15);
        check(stall == 1'b0, "R1", int'(stall), 0);
        @(negedge clk);

        // R1 R4 default count of 7 before any write
        access(1'b0, 16'hE000, -1, -1, '0, 7, "R1");
        idle(1);

        // R2 R3 R4 R5 sweep over all field values, both spaces, five addresses
        for (int v = 0; v < 16; v++) begin
            write_reg(16'hFFF0 | 16'(v));
            #1;
            check(cfg_rdata == 16'(v), "R2", int'(cfg_rdata), v);
            for (int sp = 0; sp < 2; sp++) begin
                for (int a = 0; a < 5; a++) begin
                    int n;
                    n = (addrs[a] >= 16'hC000) ? dec((v >> (2 * sp)) & 3) : 0;
                    access(sp[0], addrs[a], -1, -1, '0, n, (addrs[a] >= 16'hC000) ? "R3" : "R5");
                    idle(1);
                end
            end
        end

        // R5 outside window with the pin held and maximum count
        write_reg(16'h000F);
        ext_wait = 1'b1;
        idle(3);
        access(1'b0, 16'hBFFF, -1, -1, '0, 0, "R5");
        access(1'b1, 16'h1234, -1, -1, '0, 0, "R5");
        ext_wait = 1'b0;
        idle(3);

        // R6 pin release sweep for each code
        for (int code = 0; code < 4; code++) begin
            write_reg(16'(code) | 16'(code << 2));
            for (int j = 0; j < 10; j++) begin
                int e;
                ext_wait = 1'b1;
                idle(3);
                e = (dec(code) > j + 2) ? dec(code) : j + 2;
                access(j[0], 16'hF00D, j, -1, '0, e, "R6");
                idle(3);
            end
        end

        // R7 write during an access leaves its length unchanged
        write_reg(16'h000F);
        access(1'b0, 16'hC800, -1, 2, 16'h0000, 7, "R7");
        idle(1);
        #1;
        check(cfg_rdata == 16'h0000, "R7", int'(cfg_rdata), 0);
        access(1'b0, 16'hC800, -1, -1, '0, 0, "R7");
        idle(1);

        // R8 back-to-back accesses each get a full count
        write_reg(16'h0006);
        access(1'b0, 16'hC000, -1, -1, '0, 3, "R8");
        access(1'b1, 16'hC001, -1, -1, '0, 1, "R8");
        access(1'b0, 16'hFFFE, -1, -1, '0, 3, "R8");
        idle(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule